// File: doc/BRIEF.md
# Single-Pin GPIO Controller with Edge Interrupt

This block runs one general-purpose I/O pin from a small register set. A configuration register holds six bits: direction, output value, reduced drive, pull enable, polarity and interrupt enable. The block turns them into the control signals an external pad model needs: output enable, output value, drive-strength select, pull-up enable and pull-down enable. The one polarity bit does two jobs. It picks the pull direction, and it picks the edge that raises the interrupt. Pulls and interrupts only act while the pin is an input.

The pad level passes through a two-flop synchronizer and then into an edge detector. A detected edge sets a sticky flag, and software clears that flag by writing one to it. The interrupt request is the flag gated by the active interrupt enable. Register reads are registered, so read data appears one clock after the address is presented. The parameter `EDGE_FEATURES` set to 0 builds a variant with no polarity and no interrupt. In that variant the polarity and interrupt-enable bits read as 0 and have no effect.

Top module: `gpio_pin`

## Requirements
- R1: Writing the configuration register (address 0) takes effect after one clock edge. Bit 0 is direction: 1 makes the pin an output with `padOutEn`=1, and `padOut` then equals bit 1 (output value).
- R2: Bit 2 (reduced drive) drives `padReducedDrive` only in output mode, for either output value. In input mode `padReducedDrive` and `padOut` are 0.
- R3: In output mode `padPullUp`, `padPullDown` and `irqReq` are 0, whatever the pull-enable and interrupt-enable bits hold.
- R4: In input mode with bit 3 (pull enable) set, bit 4 (polarity) = 0 enables the pull-up and polarity = 1 enables the pull-down. With pull enable clear, neither pull is on.
- R5: In input mode with bit 5 (interrupt enable) set, polarity 0 detects falling edges and polarity 1 detects rising edges of `padIn`. After a qualifying change of `padIn`, `irqReq` rises after the third rising clock edge, and not before.
- R6: `irqReq` is the sticky flag ANDed with the active interrupt enable. Clearing interrupt enable hides the request but keeps the flag. Setting it again brings the request back.
- R7: Writing address 1 with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged. An edge that sets the flag in the same cycle as a clear wins.
- R8: Reads are registered. Address 0 returns the configuration bits. Address 1 returns the flag in bit 0 and the pin level in bit 1. The pin level is the synchronized `padIn` in input mode and the output value in output mode.
- R9: Reset clears all configuration bits and the flag. All pad controls and `irqReq` are then 0, and reads return 0.
- R10: With `EDGE_FEATURES`=0, polarity and interrupt enable read as 0 and act as 0. `padPullDown` and `irqReq` are never 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 configuration, 1 status |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Registered read data |
| padIn | input | 1 | Level seen at the pad |
| padOutEn | output | 1 | Pad output enable |
| padOut | output | 1 | Pad output value |
| padReducedDrive | output | 1 | Reduced drive-strength select |
| padPullUp | output | 1 | Pull-up enable |
| padPullDown | output | 1 | Pull-down enable |
| irqReq | output | 1 | Interrupt request |

## Verification
Some rules are checked by the assertions on every cycle. An output pin never has a pull or an interrupt request. Both pulls are never on together. The output value and reduced drive stay quiet in input mode. A request only falls after a register write. A configuration write shows up at the pad after one edge. The bench scenarios cover what the assertions cannot see. These are the exact three-edge latency of edge detection, the polarity-to-edge mapping, a flag that persists while its enable is off, set winning over clear, and the registered read-back of level and configuration across all 64 configuration values on both variants.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  // Configuration word layout (bit positions are software visible)
  localparam int CFG_W  = 6;
  localparam int DIR_B  = 0;
  localparam int DOUT_B = 1;
  localparam int RDRV_B = 2;
  localparam int PEN_B  = 3;
  localparam int POL_B  = 4;
  localparam int IEN_B  = 5;
  // Status word layout
  localparam int FLAG_B = 0;
  localparam int LVL_B  = 1;

  // Packed so member order matches the bit positions above (dir = bit 0)
  typedef struct packed {
    logic irqEn;
    logic polarity;
    logic pullEn;
    logic reducedDrive;
    logic outData;
    logic dir;
  } pinCfg_t;

  // Control-to-datapath strobes
  typedef struct packed {
    pinCfg_t cfg;
    logic    flagClr;
  } ctlStrobe_t;

  typedef enum logic {
    ADDR_CFG  = 1'b0,
    ADDR_STAT = 1'b1
  } regSel_t;
endpackage

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_pin_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int EDGE_FEATURES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              flag,
  input  logic              level,
  output logic [DATA_W-1:0] regRdData,
  output ctlStrobe_t        strobe
);
  // Bits the variant keeps; the top two (polarity, irq enable) go without edge features
  localparam logic [CFG_W-1:0] FULL_MASK = {CFG_W{1'b1}};
  localparam logic [CFG_W-1:0] CFG_MASK  =
    (EDGE_FEATURES != 0) ? FULL_MASK : (FULL_MASK >> 2);

  regSel_t           sel;
  pinCfg_t           cfgQ;
  logic              cfgWr;
  logic              statWr;
  logic [DATA_W-1:0] cfgWord;
  logic [DATA_W-1:0] statWord;
  logic [DATA_W-1:0] rdNext;
  logic              unusedWrBits;

  assign sel    = regSel_t'(regAddr);
  assign cfgWr  = regWrEn && (sel == ADDR_CFG);
  assign statWr = regWrEn && (sel == ADDR_STAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWr) begin
      cfgQ <= pinCfg_t'(regWrData[CFG_W-1:0] & CFG_MASK);
    end
  end

  always_comb begin
    strobe.cfg     = cfgQ;
    strobe.flagClr = statWr && regWrData[FLAG_B];
  end

  always_comb begin
    cfgWord          = DATA_W'(cfgQ);
    statWord         = '0;
    statWord[FLAG_B] = flag;
    statWord[LVL_B]  = level;
    rdNext           = (sel == ADDR_CFG) ? cfgWord : statWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
    end else begin
      regRdData <= rdNext;
    end
  end

  assign unusedWrBits = ^regWrData[DATA_W-1:CFG_W];
endmodule

// File: rtl/gpio_pin_dp.sv
module gpio_pin_dp
  import gpio_pin_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int EDGE_FEATURES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       padIn,
  input  ctlStrobe_t strobe,
  output logic       padOutEn,
  output logic       padOut,
  output logic       padReducedDrive,
  output logic       padPullUp,
  output logic       padPullDown,
  output logic       irqReq,
  output logic       flag,
  output logic       level
);
  localparam int  LAST_STAGE = SYNC_STAGES - 1;
  localparam logic FEAT_ON   = (EDGE_FEATURES != 0);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   cur;
  logic                   isInput;
  logic                   polEff;
  logic                   irqArmed;
  logic                   rise;
  logic                   fall;
  logic                   edgeHit;
  logic                   flagQ;

  // Synchronizer chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= padIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST_STAGE];
  end

  assign cur      = syncQ[LAST_STAGE];
  assign isInput  = !strobe.cfg.dir;
  assign polEff   = FEAT_ON && strobe.cfg.polarity;
  assign irqArmed = FEAT_ON && isInput && strobe.cfg.irqEn;

  // Pad control decode
  always_comb begin
    padOutEn        = strobe.cfg.dir;
    padOut          = strobe.cfg.dir && strobe.cfg.outData;
    padReducedDrive = strobe.cfg.dir && strobe.cfg.reducedDrive;
    padPullUp       = isInput && strobe.cfg.pullEn && !polEff;
    padPullDown     = isInput && strobe.cfg.pullEn && polEff;
  end

  // Edge detection on the synchronized level
  assign rise    = cur && !prevQ;
  assign fall    = !cur && prevQ;
  assign edgeHit = irqArmed && (polEff ? rise : fall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (edgeHit) begin
      flagQ <= 1'b1;
    end else if (strobe.flagClr) begin
      flagQ <= 1'b0;
    end
  end

  assign flag   = flagQ;
  assign irqReq = flagQ && irqArmed;
  assign level  = strobe.cfg.dir ? strobe.cfg.outData : cur;
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_pin_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int EDGE_FEATURES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              padIn,
  output logic              padOutEn,
  output logic              padOut,
  output logic              padReducedDrive,
  output logic              padPullUp,
  output logic              padPullDown,
  output logic              irqReq
);
  ctlStrobe_t strobe;
  logic       flag;
  logic       level;

  gpio_pin_ctl #(
    .DATA_W        (DATA_W),
    .EDGE_FEATURES (EDGE_FEATURES)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .flag      (flag),
    .level     (level),
    .regRdData (regRdData),
    .strobe    (strobe)
  );

  gpio_pin_dp #(
    .SYNC_STAGES   (SYNC_STAGES),
    .EDGE_FEATURES (EDGE_FEATURES)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .padIn           (padIn),
    .strobe          (strobe),
    .padOutEn        (padOutEn),
    .padOut          (padOut),
    .padReducedDrive (padReducedDrive),
    .padPullUp       (padPullUp),
    .padPullDown     (padPullDown),
    .irqReq          (irqReq),
    .flag            (flag),
    .level           (level)
  );
endmodule

// File: rtl/gpio_pin_chk.sv
module gpio_pin_chk #(
  parameter int DATA_W        = 8,
  parameter int EDGE_FEATURES = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              padOutEn,
  input logic              padOut,
  input logic              padReducedDrive,
  input logic              padPullUp,
  input logic              padPullDown,
  input logic              irqReq
);
  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr) |=> (padOutEn == $past(regWrData[0])));

  p_input_drive_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !padOutEn |-> (!padReducedDrive && !padOut));

  p_output_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    padOutEn |-> (!padPullUp && !padPullDown && !irqReq));

  p_pull_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(padPullUp && padPullDown));

  p_irq_drop_by_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> $past(regWrEn));

  if (EDGE_FEATURES == 0) begin : g_nofeat
    p_nofeat_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
      !(irqReq || padPullDown));
  end
endmodule

bind gpio_pin gpio_pin_chk #(
  .DATA_W        (DATA_W),
  .EDGE_FEATURES (EDGE_FEATURES)
) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .regWrEn         (regWrEn),
  .regAddr         (regAddr),
  .regWrData       (regWrData),
  .padOutEn        (padOutEn),
  .padOut          (padOut),
  .padReducedDrive (padReducedDrive),
  .padPullUp       (padPullUp),
  .padPullDown     (padPullDown),
  .irqReq          (irqReq)
);

// File: tb/sim_gpio_pin.sv
`timescale 1ns/1ps
module sim_gpio_pin;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic          regAddr = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic          padIn = 1'b0;

  logic [DW-1:0] rdA, rdB;
  logic oeA, outA, redA, upA, dnA, irqA;
  logic oeB, outB, redB, upB, dnB, irqB;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  always #5 clk = ~clk;

  gpio_pin #(.DATA_W(DW), .EDGE_FEATURES(1)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdA), .padIn(padIn),
    .padOutEn(oeA), .padOut(outA), .padReducedDrive(redA),
    .padPullUp(upA), .padPullDown(dnA), .irqReq(irqA));

  gpio_pin #(.DATA_W(DW), .EDGE_FEATURES(0)) u1 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdB), .padIn(padIn),
    .padOutEn(oeB), .padOut(outB), .padReducedDrive(redB),
    .padPullUp(upB), .padPullDown(dnB), .irqReq(irqB));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected pad controls {up, down, reduced, out, oe}
  function automatic logic [4:0] padExp(input logic [5:0] c, input bit feat);
    logic pol;
    pol = feat ? c[4] : 1'b0;
    return {!c[0] && c[3] && !pol, !c[0] && c[3] && pol,
            c[0] && c[2], c[0] && c[1], c[0]};
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] va, output logic [7:0] vb);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    @(negedge clk);
    va = rdA; vb = rdB;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 pads u0", {upA, dnA, redA, outA, oeA, irqA}, 8'h00);
    chk("R9 pads u1", {upB, dnB, redB, outB, oeB, irqB}, 8'h00);
    rd(1'b0, a, b);
    chk("R9 cfg read", a, 8'h00);
    rd(1'b1, a, b);
    chk("R9 status read", a, 8'h00);

    // R1 R2 R3 R4 R8 R10: full configuration sweep on both variants
    for (int c = 0; c < 64; c++) begin
      wr(1'b0, 8'(c));
      chk("R1/R2/R3/R4 pads u0", {3'b0, upA, dnA, redA, outA, oeA}, {3'b0, padExp(6'(c), 1'b1)});
      chk("R10 pads u1", {3'b0, upB, dnB, redB, outB, oeB}, {3'b0, padExp(6'(c), 1'b0)});
      chk("R3 no irq with quiet pad", {6'b0, irqA, irqB}, 8'h00);
      rd(1'b0, a, b);
      chk("R8 cfg readback u0", a, 8'(c));
      chk("R10 cfg readback u1", b, 8'(c) & 8'h0F);
    end

    // R8 level read-back
    wr(1'b0, 8'h00);
    padIn = 1'b1; settle();
    rd(1'b1, a, b);
    chk("R8 input level high", {6'b0, a[1], b[1]}, 8'h03);
    padIn = 1'b0; settle();
    rd(1'b1, a, b);
    chk("R8 input level low", {6'b0, a[1], b[1]}, 8'h00);
    wr(1'b0, 8'h03); padIn = 1'b0;
    rd(1'b1, a, b);
    chk("R8 output level from data bit", {6'b0, a[1], b[1]}, 8'h03);
    wr(1'b0, 8'h01);
    rd(1'b1, a, b);
    chk("R8 output level low", {6'b0, a[1], b[1]}, 8'h00);

    // R5 R3 R10: edge selection and latency
    for (int pol = 0; pol < 2; pol++)
      for (int ie = 0; ie < 2; ie++)
        for (int dir = 0; dir < 2; dir++)
          for (int from = 0; from < 2; from++) begin
            logic expIrq;
            wr(1'b0, 8'h00);
            padIn = from[0]; settle();
            wr(1'b1, 8'h01);
            wr(1'b0, {2'b0, ie[0], pol[0], 3'b000, dir[0]});
            expIrq = !dir[0] && ie[0] && (pol[0] ? (from == 0) : (from == 1));
            padIn = !from[0];
            @(negedge clk);
            @(negedge clk);
            chk("R5 not before third edge", {7'b0, irqA}, 8'h00);
            @(negedge clk);
            chk("R5 edge irq u0", {7'b0, irqA}, {7'b0, expIrq});
            chk("R10 no irq u1", {7'b0, irqB}, 8'h00);
            rd(1'b1, a, b);
            chk("R5 flag readback", {7'b0, a[0]}, {7'b0, expIrq});
          end

    // R6 sticky flag hidden and restored by enable
    wr(1'b0, 8'h00); padIn = 1'b1; settle();
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h20);
    padIn = 1'b0; settle();
    chk("R6 irq on falling edge", {7'b0, irqA}, 8'h01);
    wr(1'b0, 8'h00);
    chk("R6 irq hidden when disabled", {7'b0, irqA}, 8'h00);
    rd(1'b1, a, b);
    chk("R6 flag kept while disabled", {7'b0, a[0]}, 8'h01);
    wr(1'b0, 8'h20);
    chk("R6 irq back when re-enabled", {7'b0, irqA}, 8'h01);

    // R7 write-zero ignored, write-one clears
    wr(1'b1, 8'h00);
    chk("R7 write zero keeps flag", {7'b0, irqA}, 8'h01);
    wr(1'b1, 8'h01);
    chk("R7 write one clears", {7'b0, irqA}, 8'h00);

    // R7 set wins over simultaneous clear
    padIn = 1'b1; settle();
    wr(1'b1, 8'h01);
    @(negedge clk);
    padIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 8'h01;
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R7 set beats clear", {7'b0, irqA}, 8'h01);
    wr(1'b1, 8'h01);
    chk("R7 clear after collision", {7'b0, irqA}, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule